// File: doc/BRIEF.md
# Key Wake-up Edge Flag Controller

This block watches a group of general-purpose input pins and records, per pin, that an active edge has happened. Software picks the active edge of each pin, rising or falling, through a polarity register. A detected edge sets a sticky flag. The flag stays set until software writes a one to that flag bit. The block raises a single interrupt request while any flag is set and its enable bit is also set.

The pins are asynchronous to the block clock, so each pin passes through a synchronizer chain before edge detection. Edge detection compares the synchronized level with the selected polarity. A detection is an event in which the pin's level begins to match its polarity. As a result, writing a polarity bit that the current pin level already matches also sets that flag. Software is expected to program polarity first and then clear any flags that this sets.

Three 8-bit registers sit on a simple bus: interrupt enable, edge polarity and edge flags. Each register can be read or written in any cycle.

Top module: `keywake_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: The register map is enable at address 0, polarity at address 1 and flags at address 2. Enable and polarity read back the value last written. Address 3 reads 0, and a write to it changes no register.
- R3: A polarity bit of 1 makes the pin's rising edge active, and 0 makes its falling edge active. An active edge sets the flag bit. An edge in the other direction leaves the flag unchanged.
- R4: When a pin changes between clock edges, its flag reads 1 after the (SYNC_STAGES+1)th rising clock edge and still reads 0 after the SYNC_STAGES-th edge.
- R5: A set flag stays 1 after the pin returns to its earlier level.
- R6: Writing the flag register clears each flag whose written bit is 1. Flags whose written bit is 0 are left unchanged.
- R7: When a flag is set by an edge in the same cycle that a write clears it, the flag ends at 1.
- R8: `irq` is the registered OR of (flags AND enables). It rises one clock after the enabled flag is set, and it falls one clock after the clearing write takes effect.
- R9: A polarity write that makes the bit match the pin's present synchronized level sets that flag one edge after the write. A polarity write that stops the bit matching sets no flag.
- R10: Writing the enable register never changes a flag. Enabling a flag that is already set raises `irq` one clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW (2) | Register address |
| we | input | 1 | Write strobe for the addressed register |
| wdata | input | WIDTH (8) | Write data |
| rdata | output | WIDTH (8) | Read data of the addressed register (combinational) |
| pins | input | WIDTH (8) | Asynchronous input pins |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: eight pins, a two-stage synchronizer and a two-bit address. With these values every pin can be covered by byte-wide random masks. Pin-to-flag latency is three edges, so the R4 check can sample on both sides of the set edge. With a two-bit address, the unused fourth address can be written and read. Random pin toggles, polarity changes, enable writes and clearing writes are checked against a bench model in which every event is the set of bits whose level newly matches its polarity. Directed cases cover a set and a clear on the same edge, and the timing of `irq` on the cycle before and the cycle after a change.

// File: rtl/keywake_ctrl.sv
module keywake_ctrl #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pins,
  output logic             irq
);

  localparam logic [AW-1:0] ADR_EN  = AW'(0);
  localparam logic [AW-1:0] ADR_POL = AW'(1);
  localparam logic [AW-1:0] ADR_FLG = AW'(2);

  logic [SYNC_STAGES-1:0][WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] en_q, pol_q, flag_q, match_q;
  logic [WIDTH-1:0] level, match, evt, clr;

  assign level = sync_q[SYNC_STAGES-1];
  assign match = ~(level ^ pol_q);
  assign evt   = match & ~match_q;
  assign clr   = (we && addr == ADR_FLG) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      match_q <= '1;
      en_q    <= '0;
      pol_q   <= '0;
      flag_q  <= '0;
      irq     <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], pins};
      match_q <= match;
      if (we && addr == ADR_EN)  en_q  <= wdata;
      if (we && addr == ADR_POL) pol_q <= wdata;
      flag_q  <= (flag_q & ~clr) | evt;
      irq     <= |(flag_q & en_q);
    end
  end

  always_comb begin
    case (addr)
      ADR_EN:  rdata = en_q;
      ADR_POL: rdata = pol_q;
      ADR_FLG: rdata = flag_q;
      default: rdata = '0;
    endcase
  end

endmodule

module keywake_ctrl_props #(
  parameter int WIDTH = 8,
  parameter int AW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             we,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] flag,
  input logic [WIDTH-1:0] en,
  input logic [WIDTH-1:0] evt,
  input logic             irq
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (flag == '0 && en == '0 && !irq));

  assert_flag_rise_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & ~$past(flag) & ~$past(evt)) == '0));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == AW'(2)) |=> (($past(flag) & ~flag) == '0));

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(2)) |=> ((flag & $past(wdata) & ~$past(evt)) == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (($past(evt) & ~flag) == '0));

  assert_irq_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag & en)) |=> irq);

  assert_irq_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag & en)) |=> !irq);

  assert_enable_write_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(0) && evt == '0) |=> (flag == $past(flag)));

endmodule

bind keywake_ctrl keywake_ctrl_props #(.WIDTH(WIDTH), .AW(AW)) u_props (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
  .flag(flag_q), .en(en_q), .evt(evt), .irq(irq)
);

// File: tb/keywake_ctrl_test.sv
module keywake_ctrl_test;
  localparam int W = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pins = '0;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0] m_en, m_pol, m_flag, m_lvl;

  keywake_ctrl #(.WIDTH(W), .SYNC_STAGES(SYNC), .AW(2)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .pins(pins), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] events(input logic [W-1:0] lo, input logic [W-1:0] po,
                                          input logic [W-1:0] ln, input logic [W-1:0] pn);
    return ~(ln ^ pn) & (lo ^ po);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(input string req, input logic [1:0] a, input logic [W-1:0] exp);
    logic [W-1:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk_rd("R1 en", 2'd0, 8'h00);
    chk_rd("R1 pol", 2'd1, 8'h00);
    chk_rd("R1 flag", 2'd2, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 register map
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    wr(2'd3, 8'hFF);
    chk_rd("R2 en readback", 2'd0, 8'hA5);
    chk_rd("R2 pol readback", 2'd1, 8'h3C);
    chk_rd("R2 addr3 reads 0", 2'd3, 8'h00);
    chk_rd("R2 flags after addr3 write", 2'd2, 8'h00);
    wr(2'd0, 8'h00);

    // R9 polarity change with pins low: 0->1 no set, 1->0 sets
    idle(2);
    chk_rd("R9 no set on leaving match", 2'd2, 8'h00);
    wr(2'd1, 8'h00);
    chk_rd("R9 not yet set at write edge", 2'd2, 8'h00);
    idle(1);
    chk_rd("R9 false set after polarity write", 2'd2, 8'h3C);

    // R6 write-one-to-clear
    wr(2'd2, 8'h0F);
    chk_rd("R6 partial clear", 2'd2, 8'h30);
    wr(2'd2, 8'h30);
    chk_rd("R6 full clear", 2'd2, 8'h00);

    // R3 / R4 edge direction and latency
    wr(2'd1, 8'h0F);
    idle(3);
    chk_rd("R9 no set on 0->1 pol with low pins", 2'd2, 8'h00);
    pins = 8'hFF;
    idle(SYNC);
    chk_rd("R4 not yet set", 2'd2, 8'h00);
    idle(1);
    chk_rd("R4/R3 rising edges set", 2'd2, 8'h0F);
    pins = 8'h00;
    idle(SYNC + 2);
    chk_rd("R3 falling edges set", 2'd2, 8'hFF);
    pins = 8'hFF;
    idle(SYNC + 2);
    chk_rd("R5 flags sticky", 2'd2, 8'hFF);
    wr(2'd2, 8'hFF);
    chk_rd("R6 clear all", 2'd2, 8'h00);

    // R8 interrupt timing
    wr(2'd0, 8'h01);
    idle(2);
    chk("R10 enable alone no irq", {7'd0, irq}, 8'h00);
    chk_rd("R10 enable keeps flags", 2'd2, 8'h00);
    pins = 8'hFE;
    idle(SYNC + 2);
    chk_rd("R3 inactive edge ignored", 2'd2, 8'h00);
    pins = 8'hFF;
    idle(SYNC + 1);
    chk_rd("R3 rising sets bit0", 2'd2, 8'h01);
    chk("R8 irq one cycle late", {7'd0, irq}, 8'h00);
    idle(1);
    chk("R8 irq raised", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h01);
    chk("R8 irq held at clear edge", {7'd0, irq}, 8'h01);
    idle(1);
    chk("R8 irq dropped", {7'd0, irq}, 8'h00);

    // R10 enabling an already set flag
    pins = 8'hFD;
    idle(SYNC + 2);
    pins = 8'hFF;
    idle(SYNC + 2);
    chk_rd("R10 bit1 set", 2'd2, 8'h02);
    chk("R10 no irq while disabled", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h02);
    chk("R10 irq after enable, not yet", {7'd0, irq}, 8'h00);
    chk_rd("R10 flags unchanged by enable write", 2'd2, 8'h02);
    idle(1);
    chk("R10 irq after enable", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h00);

    // R7 set wins over same-cycle clear
    pins = 8'hFE;
    idle(SYNC + 2);
    pins = 8'hFF;
    idle(SYNC);
    wr(2'd2, 8'h01);
    chk_rd("R7 set wins", 2'd2, 8'h01);
    wr(2'd2, 8'h01);
    chk_rd("R6 clear later works", 2'd2, 8'h00);

    // random phase from a known state
    pins = 8'h00;
    idle(SYNC + 2);
    wr(2'd1, 8'h00);
    idle(2);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h00);
    idle(2);
    m_en = '0; m_pol = '0; m_flag = '0; m_lvl = '0;
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [W-1:0] r;
      op = int'($urandom_range(0, 3));
      r = W'($urandom);
      case (op)
        0: begin
          m_flag |= events(m_lvl, m_pol, r, m_pol);
          m_lvl = r;
          pins = r;
        end
        1: begin
          m_flag |= events(m_lvl, m_pol, m_lvl, r);
          m_pol = r;
          wr(2'd1, r);
        end
        2: begin
          m_en = r;
          wr(2'd0, r);
        end
        default: begin
          m_flag &= ~r;
          wr(2'd2, r);
        end
      endcase
      idle(SYNC + 2);
      chk_rd("R3 random flags", 2'd2, m_flag);
      chk_rd("R2 random enable", 2'd0, m_en);
      chk_rd("R2 random polarity", 2'd1, m_pol);
      chk("R8 random irq", {7'd0, irq}, {7'd0, |(m_flag & m_en)});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule